// File: doc/BRIEF.md
# Fetch and Decode Front End with Program-Counter Operands

This block is the front of a 32-bit in-order pipeline whose instructions are all four bytes wide. A fetch stage drives an instruction address onto an instruction-memory port. It captures the returned word, together with its address, in a fetch/decode register. The decode stage names up to three source registers and reads them from an external register file through three read ports. The operand values are registered into an output bundle for the execute stage.

Register index 15 is the program counter. When a source names index 15, decode does not use the register-file value. It supplies the instruction's own address plus 8. That value is not computed from the fetch/decode register. It is taken from the live fetch PC after its increment, which always sits one word past the decoding instruction. The PC therefore always points at the next word to fetch.

A store that uses index 15 as its data source receives the address plus a design-time offset, either 8 or 12. Execute can redirect the fetch stream; a redirect discards the two younger instructions. A stall freezes everything for one cycle.

Top module: `fetch_decode_front`

## Requirements
- R1: While reset is active, `imem_addr` equals `RESET_PC` (default 0) and `op_valid` is 0.
- R2: On every clock edge with neither stall nor redirect, the fetch address advances by 4. `imem_addr` always presents the current PC.
- R3: A word fetched from address X appears on the bundle with `op_addr` = X and `op_instr` = the word, two unstalled edges after X was presented.
- R4: Source fields are A = instr[19:16], B = instr[3:0] and C = instr[15:12]. These drive `rf_idx_a/b/c`. For an index other than 15, the operand equals the register-file value returned for that index.
- R5: When source A or B is 15, the operand is `op_addr` + 8, and the register-file value is ignored.
- R6: When source C is 15, the value depends on instr[25], the store flag. It is `op_addr` + 8 when the flag is 0 and `op_addr` + `STORE_PC_OFS` (8 or 12) when the flag is 1.
- R7: An instruction at address 4 with source A = 15 gets operand 12, so a PC-relative offset of 20 forms address 32.
- R8: A redirect loads the target into the PC on the next edge and drops `op_valid` at that edge. `op_valid` stays low for one more unstalled edge. The target's instruction then appears on the following one.
- R9: A stall without redirect leaves the PC and the whole output bundle unchanged for that edge.
- R10: When stall and redirect arrive together, the redirect takes effect exactly as in R8.
- R11: Whenever the fetch/decode register holds a valid instruction, the fetch PC equals that instruction's address plus 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| stall | input | 1 | Hold PC and both pipeline registers |
| redir_valid | input | 1 | Redirect request from execute |
| redir_target | input | 32 | Word-aligned redirect target |
| imem_addr | output | 32 | Instruction fetch address (current PC) |
| imem_rdata | input | 32 | Instruction word returned for `imem_addr` in the same cycle |
| rf_idx_a | output | 4 | Register-file read index, source A |
| rf_idx_b | output | 4 | Register-file read index, source B |
| rf_idx_c | output | 4 | Register-file read index, source C |
| rf_val_a | input | 32 | Register-file data for source A |
| rf_val_b | input | 32 | Register-file data for source B |
| rf_val_c | input | 32 | Register-file data for source C |
| op_valid | output | 1 | Bundle holds a valid instruction |
| op_instr | output | 32 | Instruction word |
| op_addr | output | 32 | Instruction address |
| op_a | output | 32 | Operand A |
| op_b | output | 32 | Operand B |
| op_c | output | 32 | Operand C (store data) |

## Verification
Stall and redirect can land on the same edge, and the redirect has to win. Discarding younger work must not be blocked by the freeze. The sweep drives periodic stalls and periodic redirects with co-prime periods, so they coincide several times while the fetch stream sweeps thousands of addresses. At each coincidence the bench expects the PC to hold the target and the bundle to go invalid, not to hold still. It also expects the bubble count that follows to match a plain redirect.

// File: rtl/fetch_decode_front.sv
module fetch_decode_front #(
  parameter int          STORE_PC_OFS = 8,
  parameter logic [31:0] RESET_PC     = 32'h0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        stall,
  input  logic        redir_valid,
  input  logic [31:0] redir_target,
  output logic [31:0] imem_addr,
  input  logic [31:0] imem_rdata,
  output logic [3:0]  rf_idx_a,
  output logic [3:0]  rf_idx_b,
  output logic [3:0]  rf_idx_c,
  input  logic [31:0] rf_val_a,
  input  logic [31:0] rf_val_b,
  input  logic [31:0] rf_val_c,
  output logic        op_valid,
  output logic [31:0] op_instr,
  output logic [31:0] op_addr,
  output logic [31:0] op_a,
  output logic [31:0] op_b,
  output logic [31:0] op_c
);
  localparam logic [3:0]  PC_IDX   = 4'd15;
  localparam logic [31:0] ST_EXTRA = 32'(STORE_PC_OFS - 8);

  logic [31:0] pc_q, fd_instr, fd_addr;
  logic        fd_valid;

  // incremented fetch PC: one word past fd_addr + 4, i.e. fd_addr + 8
  wire [31:0] pc_inc  = pc_q + 32'd4;
  wire        is_st   = fd_instr[25];

  assign imem_addr = pc_q;
  assign rf_idx_a  = fd_instr[19:16];
  assign rf_idx_b  = fd_instr[3:0];
  assign rf_idx_c  = fd_instr[15:12];

  wire [31:0] src_a = (rf_idx_a == PC_IDX) ? pc_inc : rf_val_a;
  wire [31:0] src_b = (rf_idx_b == PC_IDX) ? pc_inc : rf_val_b;
  wire [31:0] src_c = (rf_idx_c != PC_IDX) ? rf_val_c :
                      is_st ? pc_inc + ST_EXTRA : pc_inc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= RESET_PC;
      fd_valid <= 1'b0;
      fd_instr <= '0;
      fd_addr  <= '0;
      op_valid <= 1'b0;
      op_instr <= '0;
      op_addr  <= '0;
      op_a     <= '0;
      op_b     <= '0;
      op_c     <= '0;
    end else if (redir_valid) begin
      pc_q     <= redir_target;
      fd_valid <= 1'b0;
      op_valid <= 1'b0;
    end else if (!stall) begin
      pc_q     <= pc_inc;
      fd_valid <= 1'b1;
      fd_instr <= imem_rdata;
      fd_addr  <= pc_q;
      op_valid <= fd_valid;
      op_instr <= fd_instr;
      op_addr  <= fd_addr;
      op_a     <= src_a;
      op_b     <= src_b;
      op_c     <= src_c;
    end
  end
endmodule

// File: rtl/fetch_decode_front_chk.sv
module fetch_decode_front_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        stall,
  input logic        redir_valid,
  input logic [31:0] redir_target,
  input logic [31:0] imem_addr,
  input logic        op_valid,
  input logic [31:0] op_instr,
  input logic [31:0] op_addr,
  input logic [31:0] op_a,
  input logic        fd_valid,
  input logic [31:0] fd_addr
);
  // R2
  pc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!stall && !redir_valid) |=> imem_addr == $past(imem_addr) + 32'd4);

  // R8
  redirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |=> (imem_addr == $past(redir_target)) && !op_valid);

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !redir_valid) |=> $stable(imem_addr) && $stable(op_valid) && $stable(op_addr));

  // R5
  pc_operand_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_instr[19:16] == 4'd15) |-> op_a == op_addr + 32'd8);

  // R11
  pc_track_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fd_valid |-> imem_addr == fd_addr + 32'd4);
endmodule

bind fetch_decode_front fetch_decode_front_chk u_chk (
  .clk(clk), .rst_n(rst_n), .stall(stall), .redir_valid(redir_valid),
  .redir_target(redir_target), .imem_addr(imem_addr), .op_valid(op_valid),
  .op_instr(op_instr), .op_addr(op_addr), .op_a(op_a),
  .fd_valid(fd_valid), .fd_addr(fd_addr)
);

// File: tb/test_fetch_decode_front.sv
module test_fetch_decode_front;
  logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0, redir = 1'b0;
  logic [31:0] tgt = '0;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [31:0] instr_at(input logic [31:0] a);
    logic [3:0] fa, fb, fc;
    fa = a[5:2] ^ 4'hE;
    fb = ~a[5:2];
    fc = a[5:2] + 4'd3;
    return {6'h2A, a[6], a[10:6], fa, fc, 8'hA5, fb};
  endfunction

  function automatic logic [31:0] rfv(input logic [3:0] i);
    return (i == 4'd15) ? 32'hDEAD_BEEF : (32'h7000_0000 | {20'h0, i, 4'h0, i});
  endfunction

  logic [31:0] ia0, ia1, oi0, oi1, oa0, oa1, a0, a1, b0, b1, c0, c1;
  logic [3:0]  xa0, xb0, xc0, xa1, xb1, xc1;
  logic        v0, v1;

  fetch_decode_front i_fetch_decode_front (
    .clk(clk), .rst_n(rst_n), .stall(stall), .redir_valid(redir), .redir_target(tgt),
    .imem_addr(ia0), .imem_rdata(instr_at(ia0)),
    .rf_idx_a(xa0), .rf_idx_b(xb0), .rf_idx_c(xc0),
    .rf_val_a(rfv(xa0)), .rf_val_b(rfv(xb0)), .rf_val_c(rfv(xc0)),
    .op_valid(v0), .op_instr(oi0), .op_addr(oa0), .op_a(a0), .op_b(b0), .op_c(c0));

  fetch_decode_front #(.STORE_PC_OFS(12)) i_fetch_decode_front12 (
    .clk(clk), .rst_n(rst_n), .stall(stall), .redir_valid(redir), .redir_target(tgt),
    .imem_addr(ia1), .imem_rdata(instr_at(ia1)),
    .rf_idx_a(xa1), .rf_idx_b(xb1), .rf_idx_c(xc1),
    .rf_val_a(rfv(xa1)), .rf_val_b(rfv(xb1)), .rf_val_c(rfv(xc1)),
    .op_valid(v1), .op_instr(oi1), .op_addr(oa1), .op_a(a1), .op_b(b1), .op_c(c1));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] opx(input logic [3:0] i, input logic [31:0] a, input logic [31:0] pcofs);
    return (i == 4'd15) ? a + pcofs : rfv(i);
  endfunction

  task automatic chk_ops(input logic [31:0] a, input logic [31:0] ins,
                         input logic [31:0] va, input logic [31:0] vb, input logic [31:0] vc, input int ofs);
    logic [31:0] e;
    e = opx(ins[19:16], a, 8);
    chk(va == e, (ins[19:16] == 4'd15) ? "R5 op_a" : "R4 op_a", va, e);
    e = opx(ins[3:0], a, 8);
    chk(vb == e, (ins[3:0] == 4'd15) ? "R5 op_b" : "R4 op_b", vb, e);
    e = opx(ins[15:12], a, ins[25] ? 32'(ofs) : 32'd8);
    chk(vc == e, (ins[15:12] == 4'd15) ? "R6 op_c" : "R4 op_c", vc, e);
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%h exp=%h", 32'd0, 32'd1);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp_pc, exp_next, p_addr;
    logic p_valid;
    int bubbles;
    bit seen4;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(v0 == 1'b0 && v1 == 1'b0, "R1 op_valid in reset", {31'd0, v0}, 32'd0);
    chk(ia0 == 32'd0 && ia1 == 32'd0, "R1 imem_addr in reset", ia0, 32'd0);
    rst_n = 1'b1;
    exp_pc = 0; exp_next = 0; bubbles = 1; seen4 = 0;
    p_valid = 0; p_addr = 0;
    for (int cyc = 0; cyc < 3000; cyc++) begin
      redir = (cyc % 37) == 36;
      stall = (cyc % 11) == 5;
      tgt = 32'((cyc * 52) % 1024);
      @(posedge clk);
      @(negedge clk);
      if (redir) begin
        exp_pc = tgt; exp_next = tgt; bubbles = 1;
        chk(!v0 && !v1, stall ? "R10 redirect over stall flush" : "R8 redirect flush", {31'd0, v0}, 32'd0);
      end else if (stall) begin
        chk(v0 == p_valid && oa0 == p_addr, "R9 stall hold", oa0, p_addr);
      end else begin
        exp_pc += 4;
        if (bubbles > 0) begin
          bubbles--;
          chk(!v0 && !v1, "R8 bubble", {31'd0, v0}, 32'd0);
        end else begin
          chk(v0 && v1, "R3 valid", {31'd0, v0}, 32'd1);
          chk(oa0 == exp_next && oa1 == exp_next, "R3 op_addr", oa0, exp_next);
          chk(oi0 == instr_at(exp_next) && oi1 == oi0, "R3 op_instr", oi0, instr_at(exp_next));
          chk_ops(oa0, oi0, a0, b0, c0, 8);
          chk_ops(oa1, oi1, a1, b1, c1, 12);
          if (exp_next == 32'd4 && !seen4) begin
            seen4 = 1;
            chk(a0 + 32'd20 == 32'd32, "R7 pc-relative address", a0 + 32'd20, 32'd32);
          end
          exp_next += 4;
        end
      end
      chk(ia0 == exp_pc && ia1 == exp_pc, "R2 fetch address", ia0, exp_pc);
      p_valid = v0; p_addr = oa0;
    end
    chk(seen4, "R7 address 4 reached", {31'd0, seen4}, 32'd1);
    redir = 0; stall = 0;
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule